// File: doc/BRIEF.md
# Disk Channel Task-File Register Interface

This block is the host-facing register front end of one ATA-style disk channel. A byte-wide bus reaches it through two address windows: an eight-byte command window and a one-byte control window. The block decodes the address and sets the register according to the access direction. In the command window, offset 1 is the error byte on reads and the feature byte on writes. Offset 7 is the status byte on reads and the command byte on writes. The single control byte returns alternate status on reads and loads the device-control register on writes.

Six parameter registers are held locally and are offered to the transfer sequencer as plain outputs: feature, sector count, sector number, cylinder low, cylinder high and drive/head. The device-control register is held the same way. A command write, a data-port read and a data-port write are each passed on as a single-cycle strobe in the same cycle as the bus access. The block also owns the channel interrupt line. The sequencer requests an interrupt with a pulse, and the host clears it by reading status or by masking it through device-control.

Top module: `taskfile_regs`

## Requirements
- R1: While reset is held, and at the first sample after reset, busRdata, busErr and irqOut are 0, and all six parameter outputs and devCtrlOut are 0.
- R2: A write to command offsets 1 to 6 stores the byte (1 feature, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head), and the stored byte appears on its output after the edge. A read of offsets 2 to 6 returns the stored byte. A read of offset 1 returns seqError.
- R3: A read of command offset 7 returns seqStatus on busRdata after the edge. It also clears irqOut unless a request arrives in the same cycle.
- R4: A read of the control address returns seqStatus and leaves irqOut unchanged.
- R5: A write to command offset 7 raises cmdValid in that same cycle with cmdByte equal to busWdata. It changes no parameter register.
- R6: An access to command offset 0 raises dataRdEn (read) or dataWrEn (write) in the same cycle. A write presents busWdata on dataWdata. A read returns dataRdata on busRdata after the edge.
- R7: A seqIrqReq pulse sets irqOut at the next edge when the effective device-control bit 1 is 0, and it is ignored when that bit is 1.
- R8: A control write stores the byte on devCtrlOut. If bit 1 of the byte is 1, the write clears irqOut. If bit 1 is 0, irqOut is left as it was.
- R9: When a control write and a request fall in the same cycle, bit 1 of the byte being written decides the mask. When a request and a status read fall in the same cycle, irqOut ends at 1.
- R10: An access whose address is outside both windows sets busErr for the one following cycle, raises no strobe and changes no register. If it is a read, busRdata becomes 0.
- R11: busErr is 0 after any valid access or idle cycle. busRdata changes only on reads and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| busErr | output | 1 | Decode error for the previous access |
| seqStatus | input | 8 | Status byte from the sequencer |
| seqError | input | 8 | Error byte from the sequencer |
| seqIrqReq | input | 1 | Interrupt request pulse |
| cmdValid | output | 1 | Command write strobe |
| cmdByte | output | 8 | Command byte |
| dataRdEn | output | 1 | Data-port read strobe |
| dataWrEn | output | 1 | Data-port write strobe |
| dataWdata | output | 8 | Data-port write byte |
| dataRdata | input | 8 | Data-port byte from the sector buffer |
| featureOut | output | 8 | Feature register |
| secCountOut | output | 8 | Sector count register |
| secNumOut | output | 8 | Sector number register |
| cylLoOut | output | 8 | Cylinder low register |
| cylHiOut | output | 8 | Cylinder high register |
| devHeadOut | output | 8 | Drive/head register |
| devCtrlOut | output | 8 | Device-control register |
| irqOut | output | 1 | Channel interrupt level |

## Verification
The three strobes and their payload bytes are combinational, so they are due in the access cycle itself. The bench checks them 1 ns after it drives the inputs. Read data, the error flag, the interrupt level and the stored registers each pass through one flop, so they are due one edge after the access. The bench compares them against its model at the falling edge that follows. The model updates at the rising edge from the same input values the design sees, so the same-cycle priority cases in R9 are judged edge for edge.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int NUM_PARAM = 6;
  localparam int OFS_W     = 3;
  localparam int WIN_BYTES = 1 << OFS_W;

  typedef struct packed {
    logic [NUM_PARAM-1:0] wrParam;
    logic                 wrCtrl;
    logic                 doRead;
    logic                 rdData;
    logic                 rdErrReg;
    logic                 rdStatus;
    logic                 rdAlt;
    logic                 rdParam;
    logic                 badAcc;
    logic [OFS_W-1:0]     ofs;
  } tfStrobe_t;
endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import tf_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_BASE  = 8'h40,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h4E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrMaskBit,
  input  logic              ctrlMaskBit,
  input  logic              seqIrqReq,
  output tfStrobe_t         strb,
  output logic              cmdValid,
  output logic              dataRdEn,
  output logic              dataWrEn,
  output logic              irqOut
);
  localparam logic [ADDR_W:0] CMD_END = {1'b0, CMD_BASE} + (ADDR_W+1)'(WIN_BYTES);

  logic [ADDR_W-1:0] relAddr;
  logic              inCmd;
  logic              inCtrl;
  logic [OFS_W-1:0]  ofs;
  logic              cmdRd;
  logic              cmdWr;
  logic              effMask;

  assign relAddr = busAddr - CMD_BASE;
  assign ofs     = relAddr[OFS_W-1:0];
  assign inCmd   = ({1'b0, busAddr} >= {1'b0, CMD_BASE}) && ({1'b0, busAddr} < CMD_END);
  assign inCtrl  = (busAddr == CTRL_BASE);
  assign cmdRd   = busSel && !busWe && inCmd;
  assign cmdWr   = busSel && busWe && inCmd;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PARAM; gi++) begin : g_wr
      assign strb.wrParam[gi] = cmdWr && (ofs == OFS_W'(gi + 1));
    end
  endgenerate

  always_comb begin
    strb.wrCtrl   = busSel && busWe && inCtrl;
    strb.doRead   = busSel && !busWe;
    strb.rdData   = cmdRd && (ofs == '0);
    strb.rdErrReg = cmdRd && (ofs == OFS_W'(1));
    strb.rdStatus = cmdRd && (ofs == '1);
    strb.rdAlt    = busSel && !busWe && inCtrl;
    strb.rdParam  = cmdRd && (ofs != '0) && (ofs != OFS_W'(1)) && (ofs != '1);
    strb.badAcc   = busSel && !inCmd && !inCtrl;
    strb.ofs      = ofs;
  end

  assign cmdValid = cmdWr && (ofs == '1);
  assign dataRdEn = strb.rdData;
  assign dataWrEn = cmdWr && (ofs == '0);

  // The mask follows a device-control write in the same cycle.
  assign effMask = strb.wrCtrl ? wrMaskBit : ctrlMaskBit;

  always_ff @(posedge clk) begin
    if (!rstN)              irqOut <= 1'b0;
    else if (effMask)       irqOut <= 1'b0;
    else if (seqIrqReq)     irqOut <= 1'b1;
    else if (strb.rdStatus) irqOut <= 1'b0;
  end
endmodule

// File: rtl/tf_dp.sv
module tf_dp
  import tf_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  tfStrobe_t                 strb,
  input  logic [7:0]                busWdata,
  input  logic [7:0]                seqStatus,
  input  logic [7:0]                seqError,
  input  logic [7:0]                dataRdata,
  output logic [7:0]                busRdata,
  output logic                      busErr,
  output logic [NUM_PARAM-1:0][7:0] paramQ,
  output logic [7:0]                devCtrlQ
);
  logic [7:0] paramSel;
  logic [7:0] rdMux;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PARAM; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)                paramQ[gi] <= '0;
        else if (strb.wrParam[gi]) paramQ[gi] <= busWdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            devCtrlQ <= '0;
    else if (strb.wrCtrl) devCtrlQ <= busWdata;
  end

  always_comb begin
    paramSel = '0;
    for (int i = 0; i < NUM_PARAM; i++) begin
      if (strb.ofs == OFS_W'(i + 1)) paramSel = paramQ[i];
    end
  end

  always_comb begin
    if (strb.badAcc)                      rdMux = '0;
    else if (strb.rdData)                 rdMux = dataRdata;
    else if (strb.rdErrReg)               rdMux = seqError;
    else if (strb.rdStatus || strb.rdAlt) rdMux = seqStatus;
    else if (strb.rdParam)                rdMux = paramSel;
    else                                  rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      if (strb.doRead) busRdata <= rdMux;
      busErr <= strb.badAcc;
    end
  end
endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
  import tf_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_BASE  = 8'h40,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h4E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busErr,
  input  logic [7:0]        seqStatus,
  input  logic [7:0]        seqError,
  input  logic              seqIrqReq,
  output logic              cmdValid,
  output logic [7:0]        cmdByte,
  output logic              dataRdEn,
  output logic              dataWrEn,
  output logic [7:0]        dataWdata,
  input  logic [7:0]        dataRdata,
  output logic [7:0]        featureOut,
  output logic [7:0]        secCountOut,
  output logic [7:0]        secNumOut,
  output logic [7:0]        cylLoOut,
  output logic [7:0]        cylHiOut,
  output logic [7:0]        devHeadOut,
  output logic [7:0]        devCtrlOut,
  output logic              irqOut
);
  tfStrobe_t                 strb;
  logic [NUM_PARAM-1:0][7:0] paramQ;
  logic [7:0]                devCtrlQ;

  tf_ctrl #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CTRL_BASE(CTRL_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .wrMaskBit(busWdata[1]), .ctrlMaskBit(devCtrlQ[1]), .seqIrqReq(seqIrqReq),
    .strb(strb), .cmdValid(cmdValid), .dataRdEn(dataRdEn), .dataWrEn(dataWrEn),
    .irqOut(irqOut)
  );

  tf_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .seqStatus(seqStatus), .seqError(seqError), .dataRdata(dataRdata),
    .busRdata(busRdata), .busErr(busErr), .paramQ(paramQ), .devCtrlQ(devCtrlQ)
  );

  assign cmdByte     = busWdata;
  assign dataWdata   = busWdata;
  assign featureOut  = paramQ[0];
  assign secCountOut = paramQ[1];
  assign secNumOut   = paramQ[2];
  assign cylLoOut    = paramQ[3];
  assign cylHiOut    = paramQ[4];
  assign devHeadOut  = paramQ[5];
  assign devCtrlOut  = devCtrlQ;
endmodule

// File: rtl/taskfile_regs_chk.sv
module taskfile_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_BASE  = 8'h40,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h4E
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              busErr,
  input logic              seqIrqReq,
  input logic              cmdValid,
  input logic [7:0]        cmdByte,
  input logic              dataRdEn,
  input logic              dataWrEn,
  input logic [7:0]        dataWdata,
  input logic [7:0]        devCtrlOut,
  input logic              irqOut
);
  localparam logic [ADDR_W:0] LAST_CMD = {1'b0, CMD_BASE} + (ADDR_W+1)'(7);

  logic statusAddr, ctrlAddr, inWin, ctrlWr;
  assign statusAddr = ({1'b0, busAddr} == LAST_CMD);
  assign ctrlAddr   = (busAddr == CTRL_BASE);
  assign inWin      = ({1'b0, busAddr} >= {1'b0, CMD_BASE}) && ({1'b0, busAddr} <= LAST_CMD);
  assign ctrlWr     = busSel && busWe && ctrlAddr;

  a_r3_status_clears: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && statusAddr && !seqIrqReq |=> !irqOut);
  a_r4_alt_keeps_irq: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && ctrlAddr && !seqIrqReq |=> $stable(irqOut));
  a_r5_cmd_byte: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdByte == busWdata) && busSel && busWe);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, dataRdEn, dataWrEn}));
  a_r6_wdata: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |-> dataWdata == busWdata);
  a_r7_req_sets: assert property (@(posedge clk) disable iff (!rstN)
    seqIrqReq && !devCtrlOut[1] && !ctrlWr |=> irqOut);
  a_r7_masked: assert property (@(posedge clk) disable iff (!rstN)
    devCtrlOut[1] && !irqOut && !ctrlWr |=> !irqOut);
  a_r8_mask_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && busWdata[1] |=> !irqOut);
  a_r10_err_flag: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !inWin && !ctrlAddr |=> busErr);
  a_r11_no_err: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !busErr);
endmodule

bind taskfile_regs taskfile_regs_chk #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CTRL_BASE(CTRL_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .busErr(busErr), .seqIrqReq(seqIrqReq), .cmdValid(cmdValid),
  .cmdByte(cmdByte), .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataWdata(dataWdata),
  .devCtrlOut(devCtrlOut), .irqOut(irqOut)
);

// File: tb/test_taskfile_regs.sv
`timescale 1ns/1ps
module test_taskfile_regs;
  localparam int         ADDR_W = 8;
  localparam logic [7:0] CMDB   = 8'h40;
  localparam logic [7:0] CTLB   = 8'h4E;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWe = 0, seqIrqReq = 0;
  logic [7:0] busAddr = 0, busWdata = 0, seqStatus = 0, seqError = 0, dataRdata = 0;
  logic [7:0] busRdata, cmdByte, dataWdata, devCtrlOut;
  logic [7:0] featureOut, secCountOut, secNumOut, cylLoOut, cylHiOut, devHeadOut;
  logic busErr, cmdValid, dataRdEn, dataWrEn, irqOut;

  always #5 clk = ~clk;

  taskfile_regs #(.ADDR_W(ADDR_W), .CMD_BASE(CMDB), .CTRL_BASE(CTLB)) i_taskfile_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .seqStatus(seqStatus),
    .seqError(seqError), .seqIrqReq(seqIrqReq), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataWdata(dataWdata), .dataRdata(dataRdata),
    .featureOut(featureOut), .secCountOut(secCountOut), .secNumOut(secNumOut),
    .cylLoOut(cylLoOut), .cylHiOut(cylHiOut), .devHeadOut(devHeadOut),
    .devCtrlOut(devCtrlOut), .irqOut(irqOut)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;
  // Reference model state
  int mPar[1:6];
  int mCtrl = 0, mRd = 0, mErr = 0, mIrq = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit inCmdW(logic [7:0] a);
    return (a >= CMDB) && (a < CMDB + 8);
  endfunction

  task automatic checkRegs(string tag);
    chk(tag, "busRdata", int'(busRdata), mRd);
    chk(tag, "busErr", int'(busErr), mErr);
    chk(tag, "irqOut", int'(irqOut), mIrq);
    chk(tag, "featureOut", int'(featureOut), mPar[1]);
    chk(tag, "secCountOut", int'(secCountOut), mPar[2]);
    chk(tag, "secNumOut", int'(secNumOut), mPar[3]);
    chk(tag, "cylLoOut", int'(cylLoOut), mPar[4]);
    chk(tag, "cylHiOut", int'(cylHiOut), mPar[5]);
    chk(tag, "devHeadOut", int'(devHeadOut), mPar[6]);
    chk(tag, "devCtrlOut", int'(devCtrlOut), mCtrl);
  endtask

  task automatic step(string tag);
    bit cmd, ctl, bad, stRd, effMask;
    int ofs;
    cmd = inCmdW(busAddr);
    ctl = (busAddr == CTLB);
    ofs = int'(busAddr) - int'(CMDB);
    #1;
    chk(tag, "cmdValid", int'(cmdValid), int'(busSel && busWe && cmd && ofs == 7));
    chk(tag, "dataRdEn", int'(dataRdEn), int'(busSel && !busWe && cmd && ofs == 0));
    chk(tag, "dataWrEn", int'(dataWrEn), int'(busSel && busWe && cmd && ofs == 0));
    if (cmdValid) chk(tag, "cmdByte", int'(cmdByte), int'(busWdata));
    if (dataWrEn) chk(tag, "dataWdata", int'(dataWdata), int'(busWdata));
    @(posedge clk);
    bad  = busSel && !cmd && !ctl;
    stRd = busSel && !busWe && cmd && ofs == 7;
    mErr = int'(bad);
    if (busSel && !busWe) begin
      if (bad)            mRd = 0;
      else if (ctl)       mRd = int'(seqStatus);
      else if (ofs == 0)  mRd = int'(dataRdata);
      else if (ofs == 1)  mRd = int'(seqError);
      else if (ofs == 7)  mRd = int'(seqStatus);
      else                mRd = mPar[ofs];
    end
    effMask = (busSel && busWe && ctl) ? busWdata[1] : mCtrl[1];
    if (effMask)        mIrq = 0;
    else if (seqIrqReq) mIrq = 1;
    else if (stRd)      mIrq = 0;
    if (busSel && busWe && cmd && ofs >= 1 && ofs <= 6) mPar[ofs] = int'(busWdata);
    if (busSel && busWe && ctl) mCtrl = int'(busWdata);
    @(negedge clk);
    checkRegs(tag);
  endtask

  task automatic acc(bit we, logic [7:0] a, logic [7:0] d, bit req, string tag);
    busSel = 1; busWe = we; busAddr = a; busWdata = d; seqIrqReq = req;
    step(tag);
    busSel = 0; busWe = 0; seqIrqReq = 0;
  endtask

  task automatic idle(bit req, string tag);
    busSel = 0; seqIrqReq = req;
    step(tag);
    seqIrqReq = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    for (int k = 1; k <= 6; k++) mPar[k] = 0;
    repeat (3) @(negedge clk);
    checkRegs("R1");                        // R1 during reset
    rstN = 1;
    idle(0, "R1");                          // R1 first sample after reset

    // R2: parameter registers store and read back
    for (int k = 1; k <= 6; k++) acc(1, CMDB + 8'(k), 8'(8'h11 * k + 3), 0, "R2");
    for (int k = 2; k <= 6; k++) acc(0, CMDB + 8'(k), 8'h00, 0, "R2");
    seqError = 8'h5A;
    acc(0, CMDB + 8'd1, 8'h00, 0, "R2");    // offset 1 read gives error byte

    // R7 / R4 / R3: interrupt set, alternate status, status clear
    seqStatus = 8'h58;
    idle(1, "R7");
    acc(0, CTLB, 8'h00, 0, "R4");
    seqStatus = 8'h50;
    acc(0, CMDB + 8'd7, 8'h00, 0, "R3");
    acc(0, CMDB + 8'd7, 8'h00, 0, "R3");

    // R8 / R7: masking
    acc(1, CTLB, 8'h02, 0, "R8");
    idle(1, "R7");                          // masked request ignored
    acc(1, CTLB, 8'h00, 0, "R8");
    idle(1, "R7");
    acc(1, CTLB, 8'h04, 0, "R8");           // bit 1 clear: irq stays
    acc(1, CTLB, 8'h06, 0, "R8");           // bit 1 set: irq cleared

    // R9: same-cycle priorities
    acc(1, CTLB, 8'h00, 1, "R9");           // new value unmasks: set
    acc(0, CMDB + 8'd7, 8'h00, 1, "R9");    // request beats status read
    acc(1, CTLB, 8'h02, 1, "R9");           // mask write beats request
    acc(1, CTLB, 8'h00, 0, "R9");

    // R5 command, R6 data port
    acc(1, CMDB + 8'd7, 8'hC8, 0, "R5");
    dataRdata = 8'hA5;
    acc(0, CMDB, 8'h00, 0, "R6");
    acc(1, CMDB, 8'h3C, 0, "R6");

    // R10 bad addresses
    acc(0, 8'h00, 8'h00, 0, "R10");
    acc(1, 8'h00, 8'hFF, 0, "R10");
    acc(1, CMDB + 8'd8, 8'hEE, 0, "R10");
    acc(0, CTLB + 8'd1, 8'h00, 0, "R10");
    acc(1, CMDB - 8'd1, 8'h77, 0, "R10");

    // R11 hold behaviour
    acc(0, CMDB + 8'd3, 8'h00, 0, "R11");
    idle(0, "R11");
    acc(1, CMDB + 8'd4, 8'h99, 0, "R11");
    idle(0, "R11");

    // R11 mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = CTLB;
        1: a = 8'($urandom_range(0, 255));
        default: a = CMDB + 8'($urandom_range(0, 7));
      endcase
      seqStatus = 8'($urandom); seqError = 8'($urandom); dataRdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 3) == 0, "R11");
      else acc(1'($urandom), a, 8'($urandom), $urandom_range(0, 3) == 0, "R11");
    end

    done = 1;
    summary();
  end
endmodule